// File: doc/BRIEF.md
# Bus-Loadable Macrocell Register Bank

This block is a bank of sixteen register cells. Each cell normally runs under local logic: its own data input with clock enable, an active-high preset and an active-high clear. The bank also answers at a small window in a microcontroller's address space. The bank is split into two byte lanes, so an 8-bit processor can overwrite any lane or read it back. This lets the cells serve as loadable counters, shift registers, mailboxes or handshake flags.

A processor write into a lane takes priority over every local control of that lane's cells. A single mode input chooses how the write lands. In edge mode the lane takes the value on the trailing edge of the write strobe. In level mode the lane tracks the bus for as long as the strobe is asserted. All bus inputs share one system clock and pass through a sampling pipeline of parameterised depth before they act.

Top module: `mcell_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every cell output is 0 until something loads or sets a cell.
- R2: Cells are grouped into byte lanes. Lane address 0 holds cell bits 7:0 and lane address 1 holds bits 15:8. A write changes only the addressed lane.
- R3: While a bus load is acting on a lane, the clear, preset and clock-enable inputs of that lane's cells are ignored. The cells take the bus data. The other lane keeps running under its own controls.
- R4: With level_mode = 0, a write lands only after the write strobe deasserts. It uses the data, address and chip select sampled in the strobe's last asserted cycle. The cells do not change while the strobe is held.
- R5: With level_mode = 1, the addressed lane follows the write data for as long as the strobe and chip select are both asserted. The lane keeps the last value once the strobe drops.
- R6: Without a bus load, each cell obeys the following priority: a clear of 1 forces 0, otherwise a preset of 1 forces 1, otherwise a clock enable of 1 loads the cell's data input.
- R7: Without a bus load, a cell whose clear, preset and clock enable are all 0 keeps its value.
- R8: While chip select and the read strobe are both 1, bus_rdata shows the addressed lane's present cell values. Otherwise bus_rdata is 0.
- R9: A write strobe asserted while chip select is 0 leaves every cell unchanged, in both modes.
- R10: A bus load reaches the cell outputs SYNC_STAGES + 1 clock edges after the strobe transition that triggers it is first sampled. In edge mode that transition is the deassertion; in level mode it is the assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Chip select from the address decode |
| bus_addr | input | 1 | Lane select (LANE_AW bits) |
| bus_wr | input | 1 | Write strobe, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wdata | input | 8 | Write data (BUS_W bits) |
| bus_rdata | output | 8 | Readback data, 0 when not selected |
| level_mode | input | 1 | 0 = edge loading, 1 = level loading |
| cell_d | input | 16 | Per-cell data input |
| cell_ce | input | 16 | Per-cell clock enable |
| cell_set | input | 16 | Per-cell preset, active high |
| cell_clr | input | 16 | Per-cell clear, active high |
| cell_q | output | 16 | Cell outputs |

## Verification
Every 8-bit value is written into each lane under both load modes and then read back. This sweep tells a dropped bit or a swapped lane apart from a correct load, and it checks that edge mode ignores bus data that changes after the strobe drops. The local controls are tested in one shot by giving cell i the control pattern i[3:0]. All sixteen clear/preset/enable/data combinations are then seen at once, from an all-zero start and from an all-one start, so the priority and the hold case are both pinned down. Further cases hold the strobe asserted while data moves or while a clear is held on every cell. These cases separate level following from edge capture and show the bus winning over local logic. A write with chip select low and reads with a strobe missing show that the unselected paths stay quiet.

// File: rtl/mcell_bank_pkg.sv
package mcell_bank_pkg;
   typedef enum logic {
      LOAD_ON_TRAIL = 1'b0,
      LOAD_FOLLOW   = 1'b1
   } load_mode_e;

   function automatic int lane_addr_w(input int lanes);
      return (lanes > 1) ? $clog2(lanes) : 1;
   endfunction
endpackage

// File: rtl/strobe_sync.sv
// Samples the bus strobe together with its qualifiers through a pipeline so
// that strobe, chip select, lane address and data stay aligned.
module strobe_sync #(
   parameter int STAGES = 2,
   parameter int AW     = 1,
   parameter int DW     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_wr,
   input  logic          in_cs,
   input  logic [AW-1:0] in_addr,
   input  logic [DW-1:0] in_data,
   output logic          cur_wr,
   output logic          cur_cs,
   output logic [AW-1:0] cur_addr,
   output logic [DW-1:0] cur_data,
   output logic          prv_wr,
   output logic          prv_cs,
   output logic [AW-1:0] prv_addr,
   output logic [DW-1:0] prv_data
);
   localparam int BW = 2 + AW + DW;

   if (STAGES < 1) begin : g_bad_stages
      $error("strobe_sync: STAGES must be at least 1");
   end

   logic [STAGES:0][BW-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= '0;
      end else begin
         pipe[0] <= {in_wr, in_cs, in_addr, in_data};
         for (int s = 1; s <= STAGES; s++) begin
            pipe[s] <= pipe[s-1];
         end
      end
   end

   assign {cur_wr, cur_cs, cur_addr, cur_data} = pipe[STAGES-1];
   assign {prv_wr, prv_cs, prv_addr, prv_data} = pipe[STAGES];
endmodule

// File: rtl/load_ctrl.sv
// Decides which lane the bus loads this cycle and with what data.
module load_ctrl #(
   parameter int NUM_LANES = 2,
   parameter int AW        = 1,
   parameter int DW        = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 level_mode,
   input  logic                 cur_wr,
   input  logic                 cur_cs,
   input  logic [AW-1:0]        cur_addr,
   input  logic [DW-1:0]        cur_data,
   input  logic                 prv_wr,
   input  logic                 prv_cs,
   input  logic [AW-1:0]        prv_addr,
   input  logic [DW-1:0]        prv_data,
   output logic [NUM_LANES-1:0] lane_load,
   output logic [DW-1:0]        load_data
);
   import mcell_bank_pkg::*;

   load_mode_e mode;
   logic       follow_hit;
   logic       trail_hit;

   assign mode       = load_mode_e'(level_mode);
   assign follow_hit = cur_wr & cur_cs;
   assign trail_hit  = prv_wr & ~cur_wr & prv_cs;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_sel
      always_comb begin
         if (mode == LOAD_FOLLOW) begin
            lane_load[l] = follow_hit && (cur_addr == AW'(l));
         end else begin
            lane_load[l] = trail_hit && (prv_addr == AW'(l));
         end
      end
   end

   assign load_data = (mode == LOAD_FOLLOW) ? cur_data : prv_data;

   // R2: a bus access never loads more than one lane.
   p_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_load));

   // R4: in edge mode no load happens while the sampled strobe is still high.
   p_edge_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && cur_wr) |-> (lane_load == '0));

   // R9: chip select low at the sampling stage means no load.
   p_cs_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (level_mode && !cur_cs) |-> (lane_load == '0));
endmodule

// File: rtl/cell_lane.sv
// One byte lane of register cells with bus-load override.
module cell_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic [W-1:0] d,
   input  logic [W-1:0] ce,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   for (genvar b = 0; b < W; b++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[b] <= 1'b0;
         end else if (load) begin
            q[b] <= load_data[b];
         end else if (clr[b]) begin
            q[b] <= 1'b0;
         end else if (set[b]) begin
            q[b] <= 1'b1;
         end else if (ce[b]) begin
            q[b] <= d[b];
         end
      end
   end

   // R3: a bus load wins over every local control.
   p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(load_data)));

   // R6: a clear outside a load always leaves the cell at 0.
   p_clr_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ((q & $past(clr)) == '0));

   // R6: a preset without clear outside a load leaves the cell at 1.
   p_set_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ((q & ($past(set) & ~$past(clr))) == ($past(set) & ~$past(clr))));

   // R7: no control active and no load means the lane holds.
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && clr == '0 && set == '0 && ce == '0) |=> $stable(q));
endmodule

// File: rtl/rd_mux.sv
// Readback selector: AND-OR of the lanes, zero when not selected.
module rd_mux #(
   parameter int NUM_LANES = 2,
   parameter int AW        = 1,
   parameter int W         = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs,
   input  logic                   rd,
   input  logic [AW-1:0]          addr,
   input  logic [NUM_LANES*W-1:0] cells,
   output logic [W-1:0]           rdata
);
   logic [NUM_LANES-1:0] hit;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_hit
      assign hit[l] = cs & rd & (addr == AW'(l));
   end

   always_comb begin
      rdata = '0;
      for (int l = 0; l < NUM_LANES; l++) begin
         rdata = rdata | (cells[l*W +: W] & {W{hit[l]}});
      end
   end

   // R8: an unselected read returns zero.
   p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && rd) |-> (rdata == '0));
endmodule

// File: rtl/mcell_bank.sv
module mcell_bank #(
   parameter int NUM_CELLS   = 16,
   parameter int BUS_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int NUM_LANES  = NUM_CELLS / BUS_W,
   localparam int LANE_AW    = mcell_bank_pkg::lane_addr_w(NUM_LANES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_cs,
   input  logic [LANE_AW-1:0]   bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   input  logic                 level_mode,
   input  logic [NUM_CELLS-1:0] cell_d,
   input  logic [NUM_CELLS-1:0] cell_ce,
   input  logic [NUM_CELLS-1:0] cell_set,
   input  logic [NUM_CELLS-1:0] cell_clr,
   output logic [NUM_CELLS-1:0] cell_q
);
   if (NUM_CELLS % BUS_W != 0 || NUM_CELLS < BUS_W) begin : g_bad_width
      $error("mcell_bank: NUM_CELLS must be a nonzero multiple of BUS_W");
   end

   logic                 cur_wr, cur_cs, prv_wr, prv_cs;
   logic [LANE_AW-1:0]   cur_addr, prv_addr;
   logic [BUS_W-1:0]     cur_data, prv_data, load_data;
   logic [NUM_LANES-1:0] lane_load;

   strobe_sync #(.STAGES(SYNC_STAGES), .AW(LANE_AW), .DW(BUS_W)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .in_wr(bus_wr), .in_cs(bus_cs), .in_addr(bus_addr), .in_data(bus_wdata),
      .cur_wr(cur_wr), .cur_cs(cur_cs), .cur_addr(cur_addr), .cur_data(cur_data),
      .prv_wr(prv_wr), .prv_cs(prv_cs), .prv_addr(prv_addr), .prv_data(prv_data)
   );

   load_ctrl #(.NUM_LANES(NUM_LANES), .AW(LANE_AW), .DW(BUS_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .level_mode(level_mode),
      .cur_wr(cur_wr), .cur_cs(cur_cs), .cur_addr(cur_addr), .cur_data(cur_data),
      .prv_wr(prv_wr), .prv_cs(prv_cs), .prv_addr(prv_addr), .prv_data(prv_data),
      .lane_load(lane_load), .load_data(load_data)
   );

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      cell_lane #(.W(BUS_W)) u_lane (
         .clk(clk), .rst_n(rst_n),
         .load(lane_load[l]), .load_data(load_data),
         .d(cell_d[l*BUS_W +: BUS_W]), .ce(cell_ce[l*BUS_W +: BUS_W]),
         .set(cell_set[l*BUS_W +: BUS_W]), .clr(cell_clr[l*BUS_W +: BUS_W]),
         .q(cell_q[l*BUS_W +: BUS_W])
      );
   end

   rd_mux #(.NUM_LANES(NUM_LANES), .AW(LANE_AW), .W(BUS_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .cs(bus_cs), .rd(bus_rd), .addr(bus_addr),
      .cells(cell_q), .rdata(bus_rdata)
   );

   // R1: cells are zero in the first cycle after reset.
   p_reset_zero_r1: assert property (@(posedge clk)
      !rst_n |=> (cell_q == '0));
endmodule

// File: tb/mcell_bank_tb_top.sv
`timescale 1ns/1ps
module mcell_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_cs = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [0:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0, bus_rdata;
   logic        level_mode = 1'b0;
   logic [15:0] cell_d = '0, cell_ce = '0, cell_set = '0, cell_clr = '0, cell_q;
   logic [15:0] expq;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mcell_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .level_mode(level_mode),
      .cell_d(cell_d), .cell_ce(cell_ce), .cell_set(cell_set),
      .cell_clr(cell_clr), .cell_q(cell_q)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Strobe held for `hold` cycles; after release cs drops and data scrambles.
   task automatic bus_write(input logic lane, input logic [7:0] v, input logic cs, input int hold);
      @(negedge clk);
      bus_cs = cs; bus_wr = 1'b1; bus_addr = lane; bus_wdata = v;
      cyc(hold);
      bus_wr = 1'b0; bus_cs = 1'b0; bus_wdata = ~v; bus_addr = ~lane;
      cyc(4);
   endtask

   task automatic bus_read(input logic lane, input logic [7:0] exp, input string req);
      bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = lane;
      #1;
      chk(req, bus_rdata, exp);
      bus_cs = 1'b0; bus_rd = 1'b0;
   endtask

   function automatic logic [15:0] local_next(input logic [15:0] q);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) begin
         if (cell_clr[i])      r[i] = 1'b0;
         else if (cell_set[i]) r[i] = 1'b1;
         else if (cell_ce[i])  r[i] = cell_d[i];
         else                  r[i] = q[i];
      end
      return r;
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      cyc(3);
      chk("R1 during reset", cell_q, 16'h0);
      rst_n = 1'b1;
      cyc(2);
      chk("R1 after reset", cell_q, 16'h0);
      expq = 16'h0;

      // R2 R4 R5 R8: every value into every lane in both modes
      for (int m = 0; m < 2; m++) begin
         level_mode = m[0];
         for (int ln = 0; ln < 2; ln++) begin
            for (int v = 0; v < 256; v++) begin
               bus_write(ln[0], v[7:0], 1'b1, 2);
               if (ln == 0) expq[7:0] = v[7:0]; else expq[15:8] = v[7:0];
               chk(m ? "R5 R2 sweep" : "R4 R2 sweep", cell_q, expq);
               bus_read(ln[0], v[7:0], "R8 readback");
            end
         end
      end

      // R8: missing strobe or select reads zero
      bus_cs = 1'b1; bus_rd = 1'b0; bus_addr = 1'b1; #1;
      chk("R8 rd low", bus_rdata, 8'h0);
      bus_cs = 1'b0; bus_rd = 1'b1; #1;
      chk("R8 cs low", bus_rdata, 8'h0);
      bus_rd = 1'b0;

      // R9: writes with chip select low
      expq = cell_q;
      level_mode = 1'b0; bus_write(1'b0, 8'h3C, 1'b0, 3);
      chk("R9 edge cs low", cell_q, expq);
      level_mode = 1'b1; bus_write(1'b1, 8'hC3, 1'b0, 3);
      chk("R9 level cs low", cell_q, expq);

      // R4 R10: edge mode unchanged while strobe held, lands after release
      level_mode = 1'b0;
      @(negedge clk);
      bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h5A;
      cyc(5);
      chk("R4 held no change", cell_q, expq);
      bus_wr = 1'b0; bus_cs = 1'b0; bus_wdata = 8'hFF;
      cyc(2);
      chk("R10 edge not before stages+1", cell_q, expq);
      cyc(1);
      expq[7:0] = 8'h5A;
      chk("R10 R4 edge landed", cell_q, expq);

      // R5 R10: level mode follows data during the strobe, keeps last value
      level_mode = 1'b1;
      @(negedge clk);
      bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h11;
      cyc(2);
      chk("R10 level not before stages+1", cell_q, expq);
      cyc(1);
      expq[15:8] = 8'h11;
      chk("R10 R5 level landed", cell_q, expq);
      bus_wdata = 8'h99;
      cyc(4);
      expq[15:8] = 8'h99;
      chk("R5 follows", cell_q, expq);
      bus_wr = 1'b0; bus_cs = 1'b0; bus_wdata = 8'h00;
      cyc(4);
      chk("R5 keeps last", cell_q, expq);

      // R3: level load on lane 1 wins over a clear held on every cell
      @(negedge clk);
      cell_clr = 16'hFFFF;
      bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'hA5;
      cyc(4);
      chk("R3 override", cell_q, 16'hA500);
      bus_wr = 1'b0; bus_cs = 1'b0;
      cyc(4);
      chk("R3 clear resumes", cell_q, 16'h0000);
      cell_clr = '0;

      // R6 R7: cell i gets {clr,set,ce,d} = i, from all-zero then all-one
      for (int start = 0; start < 2; start++) begin
         level_mode = 1'b1;
         bus_write(1'b0, start ? 8'hFF : 8'h00, 1'b1, 1);
         bus_write(1'b1, start ? 8'hFF : 8'h00, 1'b1, 1);
         expq = start ? 16'hFFFF : 16'h0000;
         chk("R6 start", cell_q, expq);
         for (int i = 0; i < 16; i++) begin
            cell_d[i] = i[0]; cell_ce[i] = i[1]; cell_set[i] = i[2]; cell_clr[i] = i[3];
         end
         expq = local_next(expq);
         cyc(1);
         chk("R6 R7 priority", cell_q, expq);
         cell_d = '0; cell_ce = '0; cell_set = '0; cell_clr = '0;
         cyc(3);
         chk("R7 hold", cell_q, expq);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule